// File: doc/BRIEF.md
# USB Host Attach and Reset Sequencer

This block brings up a host port in hardware. Once the host-enable input is high it turns on the line pull-downs and watches the synchronized D+ and D- levels for a device to appear. When one appears it raises an attach event, waits for the device supply to settle, reads the idle line polarity to tell a low-speed device from a full-speed one, drives bus-reset signaling for a minimum time, enables start-of-frame generation, and waits for the device to recover before it declares the port ready.

All waits are counted in ticks of an external 1 ms timebase and set by parameters. The settling and reset times are raised to their minimums of 10 and 50 ticks if a smaller value is given. A port that is ready falls back to waiting for an attach when the bus shows SE0 for long enough. Dropping host enable returns the block to its off state from anywhere in the sequence.

Top module: `usb_attach_seq`

## Requirements
- R1: During reset every output is low. One clock edge after host_en is seen high, pulldn_en is high, and it stays high while host_en stays high.
- R2: dp_in and dm_in each pass through two flip-flops. An attach is taken only while the port waits with host_en high and the synchronized lines have exactly one line high. attach_pulse rises after the third clock edge following the line change. Both lines low (SE0) or both high (SE1) never attach, and nothing attaches while host_en is low.
- R3: attach_pulse is high for exactly one cycle. attach_flag is set in the same cycle and stays set until irq_clr is high at a clock edge that carries no new attach. When an attach and irq_clr coincide, the flag is set.
- R4: After the attach edge, bus_rst rises on the edge that consumes the Nth tick, with N = max(SETTLE_MS, 10). The default is 100.
- R5: When bus_rst rises, speed_low is loaded: 0 if the synchronized lines read D+ = 1 and D- = 0 (the full-speed idle state), and 1 otherwise. It holds until the port returns to waiting or off.
- R6: bus_rst stays high for exactly max(RESET_MS, 50) ticks (default 50) and then falls.
- R7: sof_en is low from host enable until reset ends. It rises in the same cycle that bus_rst falls, and it is never high together with bus_rst.
- R8: dev_ready rises after RECOVER_MS ticks (default 10) with sof_en high, and it is only ever high together with sof_en.
- R9: While ready, more than SE0_LOSS (default 2) consecutive ticks with synchronized SE0 clear dev_ready, sof_en and speed_low and return the port to waiting for an attach. A tick with either line high restarts the count.
- R10: host_en low at a clock edge clears bus_rst, sof_en, speed_low, dev_ready and pulldn_en in the next cycle, including in the middle of bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host mode enable |
| dp_in | input | 1 | Raw D+ line level |
| dm_in | input | 1 | Raw D- line level |
| tick_1ms | input | 1 | One-cycle timebase pulse, 1 ms apart |
| irq_clr | input | 1 | Clears the sticky attach flag |
| pulldn_en | output | 1 | Enable for the D+/D- pull-downs |
| bus_rst | output | 1 | Request to drive bus-reset signaling |
| sof_en | output | 1 | Start-of-frame generation enable |
| attach_pulse | output | 1 | One-cycle attach event |
| attach_flag | output | 1 | Sticky attach indication |
| speed_low | output | 1 | 1 means a low-speed device was detected |
| dev_ready | output | 1 | Device is out of reset and recovered |

## Verification
Two events can land on the same clock edge: the attach event that sets the sticky flag, and the software clear that resets it. The bench puts irq_clr high during exactly the third edge after the D+ line goes high, which is the edge where the synchronized line reaches the state machine. It then expects attach_pulse and attach_flag both high in the cycle that follows. A design that gives the clear priority shows the flag low there, and a later plain clear must still bring the flag down.

// File: rtl/uas_pkg.sv
package uas_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_SETTLE,
    ST_RESET,
    ST_RECOVER,
    ST_READY
  } uas_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/uas_sync.sv
module uas_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/uas_timer.sv
module uas_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/usb_attach_seq.sv
module usb_attach_seq
  import uas_pkg::*;
#(
  parameter int unsigned SETTLE_MS  = 100,
  parameter int unsigned RESET_MS   = 50,
  parameter int unsigned RECOVER_MS = 10,
  parameter int unsigned SE0_LOSS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_en,
  input  logic dp_in,
  input  logic dm_in,
  input  logic tick_1ms,
  input  logic irq_clr,
  output logic pulldn_en,
  output logic bus_rst,
  output logic sof_en,
  output logic attach_pulse,
  output logic attach_flag,
  output logic speed_low,
  output logic dev_ready
);

  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned SETTLE_LIM  = umax(SETTLE_MS, 10);
  localparam int unsigned RESET_LIM   = umax(RESET_MS, 50);
  localparam int unsigned RECOVER_LIM = umax(RECOVER_MS, 1);
  localparam int unsigned MAX_LIM     = umax(umax(SETTLE_LIM, RESET_LIM), RECOVER_LIM);
  localparam int          TW          = $clog2(MAX_LIM + 2);
  localparam int          DW          = $clog2(SE0_LOSS + 2);

  // line synchronizer: bit 0 = D+, bit 1 = D-
  logic [1:0] line_s;
  uas_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dm_in, dp_in}),
    .q     (line_s)
  );

  logic bus_se0, one_high, fs_idle;
  assign bus_se0  = ~line_s[0] & ~line_s[1];
  assign one_high = line_s[0] ^ line_s[1];
  assign fs_idle  = line_s[0] & ~line_s[1];

  uas_state_e state_q, state_d;
  logic       speed_q, speed_d;
  logic       flag_q, flag_d;
  logic       pulse_q, pulse_d;

  // phase timer, cleared on every state change
  logic          timed_st, tmr_clr, tmr_hit;
  logic [TW-1:0] tmr_cnt, lim_m1;

  assign timed_st = (state_q == ST_SETTLE) || (state_q == ST_RESET) ||
                    (state_q == ST_RECOVER);
  assign tmr_clr  = (state_d != state_q);

  uas_timer #(.CW(TW)) u_phase_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .tick  (tick_1ms & timed_st),
    .count (tmr_cnt)
  );

  always_comb begin
    unique case (state_q)
      ST_SETTLE:  lim_m1 = TW'(SETTLE_LIM - 1);
      ST_RESET:   lim_m1 = TW'(RESET_LIM - 1);
      ST_RECOVER: lim_m1 = TW'(RECOVER_LIM - 1);
      default:    lim_m1 = '0;
    endcase
  end

  assign tmr_hit = tick_1ms & timed_st & (tmr_cnt == lim_m1);

  // detach filter: counts consecutive SE0 ticks while ready
  logic          se0_clr, se0_loss;
  logic [DW-1:0] se0_cnt;

  assign se0_clr = (state_q != ST_READY) | ~bus_se0;

  uas_timer #(.CW(DW)) u_se0_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (se0_clr),
    .tick  (tick_1ms),
    .count (se0_cnt)
  );

  assign se0_loss = (state_q == ST_READY) & bus_se0 & tick_1ms &
                    (se0_cnt == DW'(SE0_LOSS));

  // next state
  always_comb begin
    state_d = state_q;
    speed_d = speed_q;
    flag_d  = flag_q;
    pulse_d = 1'b0;
    if (irq_clr) flag_d = 1'b0;
    if (!host_en) begin
      state_d = ST_OFF;
      speed_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: state_d = ST_WAIT;
        ST_WAIT: begin
          speed_d = 1'b0;
          if (one_high) begin
            state_d = ST_SETTLE;
            pulse_d = 1'b1;
            flag_d  = 1'b1;
          end
        end
        ST_SETTLE: if (tmr_hit) begin
          state_d = ST_RESET;
          speed_d = ~fs_idle;
        end
        ST_RESET:   if (tmr_hit) state_d = ST_RECOVER;
        ST_RECOVER: if (tmr_hit) state_d = ST_READY;
        ST_READY: if (se0_loss) begin
          state_d = ST_WAIT;
          speed_d = 1'b0;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      speed_q <= 1'b0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      speed_q <= speed_d;
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulldn_en    = (state_q != ST_OFF);
  assign bus_rst      = (state_q == ST_RESET);
  assign sof_en       = (state_q == ST_RECOVER) || (state_q == ST_READY);
  assign dev_ready    = (state_q == ST_READY);
  assign attach_pulse = pulse_q;
  assign attach_flag  = flag_q;
  assign speed_low    = speed_q;

endmodule

// File: rtl/uas_checks.sv
module uas_checks
  import uas_pkg::*;
#(
  parameter int unsigned RESET_MS = 50
) (
  input logic clk,
  input logic rst_n,
  input logic host_en,
  input logic dp_in,
  input logic dm_in,
  input logic tick_1ms,
  input logic irq_clr,
  input logic pulldn_en,
  input logic bus_rst,
  input logic sof_en,
  input logic attach_pulse,
  input logic attach_flag,
  input logic speed_low,
  input logic dev_ready
);

  localparam int unsigned RESET_LIM = umax(RESET_MS, 50);

  logic [31:0] rst_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rst_ticks <= '0;
    else if (!bus_rst) rst_ticks <= '0;
    else if (tick_1ms) rst_ticks <= rst_ticks + 32'd1;
  end

  p_pulldn_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |=> pulldn_en);

  // the two synchronizer flops plus the state register give three edges
  p_attach_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    attach_pulse |-> $past(dp_in ^ dm_in, 3));

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    attach_pulse |=> !attach_pulse);

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    attach_pulse |-> attach_flag);

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    attach_flag && !irq_clr |=> attach_flag);

  p_speed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst && $past(bus_rst) |-> $stable(speed_low));

  p_reset_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rst) && pulldn_en |-> rst_ticks == RESET_LIM);

  p_sof_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sof_en && bus_rst));

  p_sof_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rst) && pulldn_en |-> sof_en);

  p_ready_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ready |-> sof_en);

  p_detach_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_ready) |-> !speed_low && !sof_en);

  p_off_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |=> !pulldn_en && !bus_rst && !sof_en && !dev_ready && !speed_low);

endmodule

bind usb_attach_seq uas_checks #(.RESET_MS(RESET_MS)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_en      (host_en),
  .dp_in        (dp_in),
  .dm_in        (dm_in),
  .tick_1ms     (tick_1ms),
  .irq_clr      (irq_clr),
  .pulldn_en    (pulldn_en),
  .bus_rst      (bus_rst),
  .sof_en       (sof_en),
  .attach_pulse (attach_pulse),
  .attach_flag  (attach_flag),
  .speed_low    (speed_low),
  .dev_ready    (dev_ready)
);

// File: tb/sim_usb_attach_seq.sv
module sim_usb_attach_seq;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n, host_en, dp_in, dm_in, tick_1ms, irq_clr;
  logic pulldn_en, bus_rst, sof_en, attach_pulse, attach_flag, speed_low, dev_ready;
  logic v_pulldn, v_rst, v_sof, v_pulse, v_flag, v_speed, v_ready;

  usb_attach_seq u0 (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .dp_in(dp_in), .dm_in(dm_in),
    .tick_1ms(tick_1ms), .irq_clr(irq_clr), .pulldn_en(pulldn_en), .bus_rst(bus_rst),
    .sof_en(sof_en), .attach_pulse(attach_pulse), .attach_flag(attach_flag),
    .speed_low(speed_low), .dev_ready(dev_ready)
  );

  // second instance with parameters below the minimums
  usb_attach_seq #(.SETTLE_MS(3), .RESET_MS(7), .RECOVER_MS(2)) u1 (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .dp_in(dp_in), .dm_in(dm_in),
    .tick_1ms(tick_1ms), .irq_clr(irq_clr), .pulldn_en(v_pulldn), .bus_rst(v_rst),
    .sof_en(v_sof), .attach_pulse(v_pulse), .attach_flag(v_flag),
    .speed_low(v_speed), .dev_ready(v_ready)
  );

  localparam int K_ATT = 0, K_SETTLE = 1, K_SPEED = 2, K_RST = 3, K_SOF = 4, K_REC = 5;
  localparam int P_IDLE = 0, P_SET = 1, P_RST = 2, P_REC = 3, P_RDY = 4;

  typedef struct { int kind; int val; } ev_t;
  ev_t exp_q[$];

  int total = 0;
  int bad   = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string kind_req(input int k);
    case (k)
      K_ATT:    return "R2 attach";
      K_SETTLE: return "R4 settle ticks";
      K_SPEED:  return "R5 speed";
      K_RST:    return "R6 reset ticks";
      K_SOF:    return "R7 sof at reset end";
      default:  return "R8 recovery ticks";
    endcase
  endfunction

  task automatic emit(input int kind, input int val);
    ev_t e;
    if (exp_q.size() == 0) begin
      check("scoreboard unexpected event", kind, 32'hFFFF_FFFF);
    end else begin
      e = exp_q.pop_front();
      check(kind_req(e.kind), kind, e.kind);
      check(kind_req(e.kind), val, e.val);
    end
  endtask

  task automatic push_seq(input int spd, input bit full);
    exp_q.push_back('{K_ATT, 0});
    exp_q.push_back('{K_SETTLE, 100});
    exp_q.push_back('{K_SPEED, spd});
    if (full) begin
      exp_q.push_back('{K_RST, 50});
      exp_q.push_back('{K_SOF, 1});
      exp_q.push_back('{K_REC, 10});
    end
  endtask

  // monitor: samples shortly after each falling edge
  int phase = P_IDLE, cnt = 0;
  int u1_phase = P_IDLE, u1_cnt = 0, u1_settle = -1, u1_reset = -1;

  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (!pulldn_en) phase = P_IDLE;
      else begin
        case (phase)
          P_IDLE: if (attach_pulse) begin emit(K_ATT, 0); phase = P_SET; cnt = 0; end
          P_SET: if (bus_rst) begin
            emit(K_SETTLE, cnt); emit(K_SPEED, int'(speed_low)); phase = P_RST; cnt = 0;
          end
          P_RST: if (!bus_rst) begin
            emit(K_RST, cnt); emit(K_SOF, int'(sof_en)); phase = P_REC; cnt = 0;
          end
          P_REC: if (dev_ready) begin emit(K_REC, cnt); phase = P_RDY; end
          default: if (!dev_ready) phase = P_IDLE;
        endcase
        if ((phase == P_SET || phase == P_RST || phase == P_REC) && tick_1ms) cnt++;
      end
      if (u1_phase == P_IDLE && v_pulse) begin u1_phase = P_SET; u1_cnt = 0; end
      else if (u1_phase == P_SET && v_rst) begin u1_settle = u1_cnt; u1_phase = P_RST; u1_cnt = 0; end
      else if (u1_phase == P_RST && !v_rst) begin u1_reset = u1_cnt; u1_phase = P_RDY; end
      if ((u1_phase == P_SET || u1_phase == P_RST) && tick_1ms) u1_cnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick_1ms = 1'b1;
      @(negedge clk); tick_1ms = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_en = 1'b0; dp_in = 1'b0; dm_in = 1'b0;
    tick_1ms = 1'b0; irq_clr = 1'b0;
    cyc(3);
    check("R1 reset pulldn", pulldn_en, 0);
    check("R1 reset bus_rst", bus_rst, 0);
    check("R1 reset sof", sof_en, 0);
    check("R1 reset flag", attach_flag, 0);
    check("R1 reset ready", dev_ready, 0);
    check("R1 reset speed", speed_low, 0);
    @(negedge clk) rst_n = 1'b1;

    // lines active while host mode is off
    @(negedge clk) dp_in = 1'b1;
    run_ticks(3);
    check("R1 pulldn off without host_en", pulldn_en, 0);
    check("R2 no attach when host off", attach_flag, 0);
    dp_in = 1'b0;
    cyc(3);

    @(negedge clk) host_en = 1'b1;
    @(negedge clk);
    check("R1 pulldn after host_en", pulldn_en, 1);
    check("R7 sof low before reset", sof_en, 0);

    // SE1 is not an attach
    dp_in = 1'b1; dm_in = 1'b1;
    cyc(6);
    check("R2 SE1 ignored", attach_flag, 0);
    dp_in = 1'b0; dm_in = 1'b0;
    cyc(4);
    check("R2 SE0 ignored", attach_flag, 0);

    // full-speed attach, clear collides with the attach edge
    push_seq(0, 1'b1);
    @(negedge clk) dp_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 no pulse before third edge", attach_pulse, 0);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R2 pulse on third edge", attach_pulse, 1);
    check("R3 set beats clear", attach_flag, 1);
    @(negedge clk);
    check("R3 pulse one cycle", attach_pulse, 0);
    check("R3 flag sticky", attach_flag, 1);
    run_ticks(170);
    cyc(2);
    check("R8 ready full speed", dev_ready, 1);
    check("R5 full speed", speed_low, 0);
    check("R7 sof on", sof_en, 1);
    check("R6 reset released", bus_rst, 0);
    check("R4 clamp settle", u1_settle, 10);
    check("R6 clamp reset", u1_reset, 50);

    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    check("R3 clear", attach_flag, 0);

    // SE0 glitches then a real detach
    dp_in = 1'b0;
    cyc(3); run_ticks(2);
    check("R9 two SE0 ticks keep ready", dev_ready, 1);
    dp_in = 1'b1;
    cyc(3); run_ticks(2);
    dp_in = 1'b0;
    cyc(3); run_ticks(2);
    check("R9 count restarted", dev_ready, 1);
    run_ticks(1);
    check("R9 detach ready", dev_ready, 0);
    check("R9 detach sof", sof_en, 0);
    check("R9 pulldn kept", pulldn_en, 1);

    // low-speed attach
    push_seq(1, 1'b1);
    @(negedge clk) dm_in = 1'b1;
    run_ticks(170);
    cyc(2);
    check("R8 ready low speed", dev_ready, 1);
    check("R5 low speed", speed_low, 1);

    @(negedge clk) host_en = 1'b0;
    @(negedge clk);
    check("R10 ready cleared", dev_ready, 0);
    check("R10 speed cleared", speed_low, 0);
    check("R10 sof cleared", sof_en, 0);
    check("R10 pulldn cleared", pulldn_en, 0);

    // drop host enable during bus reset
    push_seq(1, 1'b0);
    @(negedge clk) host_en = 1'b1;
    run_ticks(110);
    check("R6 reset in progress", bus_rst, 1);
    @(negedge clk) host_en = 1'b0;
    @(negedge clk);
    check("R10 reset aborted", bus_rst, 0);
    check("R10 sof stays off", sof_en, 0);
    cyc(3);
    check("R4 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule